// File: doc/BRIEF.md
# Bit-Test Conditional Branch Unit

This block resolves a conditional branch whose condition is a single bit of a 64-bit source operand. The decode stage supplies the operand, a 6-bit index selecting the bit, a polarity flag choosing "branch when the bit is one" or "branch when the bit is zero", the address of the branch, a signed 16-bit word displacement, and a flag that marks the branch as sitting in the delay or forbidden slot of an earlier branch.

One cycle after an input strobe the block presents a registered result. The result holds the taken decision, the branch destination, and a request to execute the following instruction, which always runs as a 32-bit delay slot. A branch found in a slot is not evaluated. It produces a reserved-instruction exception. Operand fetch, pipeline flushing and redirection of fetch belong to the surrounding pipeline.

Top module: `btbu_top`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `res_valid`, `res_taken`, `res_target`, `res_slot_exec` and `res_trap` are all zero.
- R2: `res_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R3: With `req_pol_set`=1 and `req_in_slot`=0, `res_taken` is 1 exactly when bit `req_bit_idx` of `req_src` is 1.
- R4: With `req_pol_set`=0 and `req_in_slot`=0, `res_taken` is 1 exactly when bit `req_bit_idx` of `req_src` is 0.
- R5: Every index 0 to 63 selects its own bit. Bit 0 is the least significant bit, and both end positions behave as R3 and R4 describe.
- R6: For an evaluated branch, `res_target` = `req_pc` + 4 + sext(`req_word_ofs`) × 4, modulo 2^64, whether or not the branch is taken.
- R7: `req_word_ofs` is two's complement. Bit 15 set means a backward displacement, so 0x8000 moves back 32768 words.
- R8: For an evaluated branch, `res_slot_exec` is 1 and `res_trap` is 0, whether or not the branch is taken.
- R9: With `req_in_slot`=1, the result has `res_trap`=1, `res_taken`=0, `res_slot_exec`=0 and `res_target`=0, whatever the operand bit is.
- R10: `res_trap` and `res_taken` are never high together. In a cycle with `res_valid` low, all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_src | input | 64 | Operand containing the tested bit |
| req_bit_idx | input | 6 | Index of the tested bit |
| req_pol_set | input | 1 | 1: branch if the bit is one; 0: branch if the bit is zero |
| req_pc | input | 64 | Address of the branch instruction |
| req_word_ofs | input | 16 | Signed displacement in instruction words |
| req_in_slot | input | 1 | Branch sits in a delay or forbidden slot |
| res_valid | output | 1 | Result valid |
| res_taken | output | 1 | Branch taken |
| res_target | output | 64 | Branch destination |
| res_slot_exec | output | 1 | Execute the following instruction |
| res_trap | output | 1 | Reserved-instruction exception |

## Verification
The bit selector is driven with single-bit operands, with all-ones and all-zero operands, and with random operands, all under both polarities. This separates a wrong index or bit order from a polarity inversion. Displacements of 0, 0x7FFF, 0x8000 and -1 are applied, with addresses close to zero and close to 2^64, so that a missing sign extension, a wrong scale factor and a lost carry each give a different destination. Trapped requests use operands whose tested bit would have taken the branch, and back-to-back strobes followed by idle cycles show that valid tracks the strobe and that idle results are cleared.

// File: rtl/btbu_pkg.sv
// Shared types for the bit-test branch unit.
package btbu_pkg;

    // Decision flags produced for one request.
    typedef struct packed {
        logic taken;
        logic slot_exec;
        logic trap;
    } btbu_flags_t;

endpackage

// File: rtl/btbu_bit_pick.sv
// Selects one bit of an operand word by index.
// Assumes the index is below DATA_W. An index that is out of range yields 0.
module btbu_bit_pick #(
    parameter int DATA_W = 64,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [POS_W-1:0]  pos_i,
    output logic              bit_o
);
    logic [DATA_W-1:0] hit;

    // One-hot decode of the index, masked by the operand.
    for (genvar g = 0; g < DATA_W; g++) begin : g_sel
        assign hit[g] = word_i[g] && (pos_i == POS_W'(g));
    end

    // Collapse the masked bits into the selected value.
    assign bit_o = |hit;
endmodule

// File: rtl/btbu_target_gen.sv
// Computes pc + INSN_BYTES + sext(ofs) * INSN_BYTES, wrapping modulo 2^ADDR_W.
// Assumes the displacement is two's complement and counted in instructions.
module btbu_target_gen #(
    parameter int ADDR_W     = 64,
    parameter int OFS_W      = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [ADDR_W-1:0] target_o
);
    localparam int SHIFT   = $clog2(INSN_BYTES);
    localparam bit POW2    = ((1 << SHIFT) == INSN_BYTES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0] ofs_ext;
    logic [ADDR_W-1:0] ofs_bytes;

    // Sign-extend the displacement to address width.
    assign ofs_ext = {{(ADDR_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};

    // Scale words to bytes: a shift for power-of-two sizes, a multiply otherwise.
    if (POW2) begin : g_shift
        assign ofs_bytes = ofs_ext << SHIFT;
    end else begin : g_mul
        assign ofs_bytes = ofs_ext * STEP;
    end

    // Base is the address after the branch. The sum wraps at the address width.
    assign target_o = pc_i + STEP + ofs_bytes;
endmodule

// File: rtl/btbu_decide.sv
// Turns the selected bit, the polarity and the slot flag into the decision flags.
// Assumes a branch in a slot is never evaluated and only raises the trap.
module btbu_decide
    import btbu_pkg::*;
(
    input  logic        bit_i,
    input  logic        pol_set_i,
    input  logic        in_slot_i,
    output btbu_flags_t flags_o
);
    // Either trap, or evaluate the condition and request the delay slot.
    always_comb begin
        if (in_slot_i) begin
            flags_o.taken     = 1'b0;
            flags_o.slot_exec = 1'b0;
            flags_o.trap      = 1'b1;
        end else begin
            flags_o.taken     = pol_set_i ? bit_i : ~bit_i;
            flags_o.slot_exec = 1'b1;
            flags_o.trap      = 1'b0;
        end
    end
endmodule

// File: rtl/btbu_top.sv
// Bit-test conditional branch unit. The outputs are registered one cycle after req_valid.
// Assumes a single request per cycle. The result holds one cycle and is zero when idle.
module btbu_top
    import btbu_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 64,
    parameter int OFS_W      = 16,
    parameter int INSN_BYTES = 4,
    localparam int POS_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_src,
    input  logic [POS_W-1:0]  req_bit_idx,
    input  logic              req_pol_set,
    input  logic [ADDR_W-1:0] req_pc,
    input  logic [OFS_W-1:0]  req_word_ofs,
    input  logic              req_in_slot,
    output logic              res_valid,
    output logic              res_taken,
    output logic [ADDR_W-1:0] res_target,
    output logic              res_slot_exec,
    output logic              res_trap
);
    logic              sel_bit;
    logic [ADDR_W-1:0] tgt_calc;
    btbu_flags_t       flags;

    btbu_bit_pick #(.DATA_W(DATA_W)) i_pick (
        .word_i (req_src),
        .pos_i  (req_bit_idx),
        .bit_o  (sel_bit)
    );

    btbu_target_gen #(
        .ADDR_W     (ADDR_W),
        .OFS_W      (OFS_W),
        .INSN_BYTES (INSN_BYTES)
    ) i_tgt (
        .pc_i     (req_pc),
        .ofs_i    (req_word_ofs),
        .target_o (tgt_calc)
    );

    btbu_decide i_dec (
        .bit_i     (sel_bit),
        .pol_set_i (req_pol_set),
        .in_slot_i (req_in_slot),
        .flags_o   (flags)
    );

    // Register the result. Idle cycles and trapped requests clear the fields that do not apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_taken     <= 1'b0;
            res_target    <= '0;
            res_slot_exec <= 1'b0;
            res_trap      <= 1'b0;
        end else begin
            res_valid     <= req_valid;
            res_taken     <= req_valid && flags.taken;
            res_slot_exec <= req_valid && flags.slot_exec;
            res_trap      <= req_valid && flags.trap;
            res_target    <= (req_valid && !flags.trap) ? tgt_calc : '0;
        end
    end
endmodule

// File: rtl/btbu_checker.sv
// Temporal checks on the ports of btbu_top, attached through bind.
module btbu_checker #(
    parameter int ADDR_W     = 64,
    parameter int OFS_W      = 16,
    parameter int INSN_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_in_slot,
    input logic [ADDR_W-1:0] req_pc,
    input logic [OFS_W-1:0]  req_word_ofs,
    input logic              res_valid,
    input logic              res_taken,
    input logic [ADDR_W-1:0] res_target,
    input logic              res_slot_exec,
    input logic              res_trap
);
    logic [ADDR_W-1:0] exp_tgt;
    // Expected destination from the request fields, formed independently of the datapath.
    assign exp_tgt = req_pc + ADDR_W'(INSN_BYTES)
                   + ({{(ADDR_W-OFS_W){req_word_ofs[OFS_W-1]}}, req_word_ofs} * ADDR_W'(INSN_BYTES));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    assert_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_in_slot) |=> (res_target == $past(exp_tgt)));
    assert_eval_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_in_slot) |=> (res_slot_exec && !res_trap));
    assert_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_in_slot) |=> (res_trap && !res_taken && !res_slot_exec && res_target == '0));
    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_trap && res_taken));
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_taken && !res_trap && !res_slot_exec && res_target == '0));
endmodule

bind btbu_top btbu_checker #(
    .ADDR_W     (ADDR_W),
    .OFS_W      (OFS_W),
    .INSN_BYTES (INSN_BYTES)
) i_btbu_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_in_slot   (req_in_slot),
    .req_pc        (req_pc),
    .req_word_ofs  (req_word_ofs),
    .res_valid     (res_valid),
    .res_taken     (res_taken),
    .res_target    (res_target),
    .res_slot_exec (res_slot_exec),
    .res_trap      (res_trap)
);

// File: tb/test_btbu_top.sv
// Self-checking bench for btbu_top: directed corner cases plus seeded random requests.
module test_btbu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_src = '0;
    logic [5:0]  req_bit_idx = '0;
    logic        req_pol_set = 1'b0;
    logic [63:0] req_pc = '0;
    logic [15:0] req_word_ofs = '0;
    logic        req_in_slot = 1'b0;
    logic        res_valid, res_taken, res_slot_exec, res_trap;
    logic [63:0] res_target;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    btbu_top i_btbu_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_bit_idx(req_bit_idx), .req_pol_set(req_pol_set), .req_pc(req_pc),
        .req_word_ofs(req_word_ofs), .req_in_slot(req_in_slot),
        .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
        .res_slot_exec(res_slot_exec), .res_trap(res_trap)
    );

    // 250 MHz clock
    always #2 clk = ~clk;

    // Expected destination of an evaluated branch
    function automatic logic [63:0] ref_target(logic [63:0] pc, logic [15:0] ofs);
        logic signed [63:0] d;
        d = 64'(signed'(ofs));
        return pc + 64'd4 + 64'(d * 64'sd4);
    endfunction

    // Expected taken flag of an evaluated branch
    function automatic logic ref_taken(logic [63:0] src, logic [5:0] idx, logic pol);
        logic b;
        b = (src >> idx) & 64'd1;
        return pol ? b : !b;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Issue one request, then check the registered result after the next edge.
    task automatic issue(input string req, input logic [63:0] src, input logic [5:0] idx,
                         input logic pol, input logic [63:0] pc, input logic [15:0] ofs,
                         input logic slot);
        @(negedge clk);
        req_valid = 1'b1; req_src = src; req_bit_idx = idx; req_pol_set = pol;
        req_pc = pc; req_word_ofs = ofs; req_in_slot = slot;
        @(posedge clk); #1;
        chk(req, "valid", 64'(res_valid), 64'd1);
        if (slot) begin
            chk(req, "trap", 64'(res_trap), 64'd1);
            chk(req, "taken", 64'(res_taken), 64'd0);
            chk(req, "slot_exec", 64'(res_slot_exec), 64'd0);
            chk(req, "target", res_target, 64'd0);
        end else begin
            chk(req, "taken", 64'(res_taken), 64'(ref_taken(src, idx, pol)));
            chk(req, "target", res_target, ref_target(pc, ofs));
            chk(req, "slot_exec", 64'(res_slot_exec), 64'd1);
            chk(req, "trap", 64'(res_trap), 64'd0);
        end
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        req_valid = 1'b0; req_src = '1; req_in_slot = 1'b1; req_pol_set = 1'b1;
        @(posedge clk); #1;
        chk(req, "idle valid", 64'(res_valid), 64'd0);
        chk(req, "idle flags", {61'd0, res_taken, res_slot_exec, res_trap}, 64'd0);
        chk(req, "idle target", res_target, 64'd0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: the outputs are zero during reset
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset outputs", {59'd0, res_valid, res_taken, res_slot_exec, res_trap, |res_target}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "post-reset outputs", {59'd0, res_valid, res_taken, res_slot_exec, res_trap, |res_target}, 64'd0);

        // R3/R4/R5: end positions and single-bit operands, both polarities
        issue("R3_R5", 64'h1, 6'd0, 1'b1, 64'h1000, 16'd0, 1'b0);
        issue("R4_R5", 64'h1, 6'd0, 1'b0, 64'h1000, 16'd0, 1'b0);
        issue("R3_R5", 64'h8000_0000_0000_0000, 6'd63, 1'b1, 64'h2000, 16'd1, 1'b0);
        issue("R4_R5", 64'h8000_0000_0000_0000, 6'd63, 1'b0, 64'h2000, 16'd1, 1'b0);
        issue("R3_R5", 64'h7FFF_FFFF_FFFF_FFFF, 6'd63, 1'b1, 64'h2000, 16'd1, 1'b0);
        issue("R4_R5", 64'hFFFF_FFFF_FFFF_FFFE, 6'd0, 1'b0, 64'h2000, 16'd1, 1'b0);
        for (int i = 0; i < 64; i++) begin
            issue("R5", 64'd1 << i, 6'(i), 1'b1, 64'h4000, 16'd2, 1'b0);
            issue("R5", ~(64'd1 << ((i + 1) % 64)), 6'(i), 1'b0, 64'h4000, 16'd2, 1'b0);
        end
        idle_check("R2_R10");

        // R6/R7: displacement extremes and wraparound
        issue("R6", 64'h0, 6'd5, 1'b0, 64'h0000_0000_0001_0000, 16'h7FFF, 1'b0);
        issue("R7", 64'h0, 6'd5, 1'b0, 64'h0000_0000_0010_0000, 16'h8000, 1'b0);
        issue("R7", 64'h0, 6'd5, 1'b1, 64'h0, 16'hFFFF, 1'b0);
        issue("R6", 64'h0, 6'd5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFC, 16'h0, 1'b0);
        issue("R6", 64'h0, 6'd5, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0010, 1'b0);

        // R8/R9: a trapped request whose tested bit would have taken the branch
        issue("R9", 64'hFFFF_FFFF_FFFF_FFFF, 6'd10, 1'b1, 64'h8000, 16'd3, 1'b1);
        issue("R9", 64'h0, 6'd10, 1'b0, 64'h8000, 16'h8000, 1'b1);
        issue("R8", 64'h0, 6'd10, 1'b1, 64'h8000, 16'd3, 1'b0);
        idle_check("R2_R10");
        idle_check("R2_R10");

        // Random mix of requests and idle gaps
        for (int n = 0; n < 400; n++) begin
            logic [63:0] s, p;
            s = {$urandom(), $urandom()};
            p = {$urandom(), $urandom()};
            issue(($urandom_range(0, 7) == 0) ? "R9" : "R3_R4_R6",
                  s, 6'($urandom_range(0, 63)), 1'($urandom_range(0, 1)),
                  p, 16'($urandom()), ($urandom_range(0, 7) == 0));
            if ($urandom_range(0, 3) == 0) idle_check("R2_R10");
        end
        idle_check("R2_R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule